// File: doc/BRIEF.md
# Line Sensor Timing Controller

This block drives the control pins of a column-parallel linear image sensor from the sensor's own master clock. After system reset it waits out a power-up delay and then runs an ordered two-stage reset: first the sensor's PLL reset line is pulled low for a fixed number of clocks, and only once it is released is the all-pixel reset line pulled low for the same count. Both lines are active low. When the second reset is released, the ready flag rises and stays high.

After ready, and while enable is high, the block produces a periodic master start pulse. Each period opens with a falling edge, so pixel integration starts there. The pulse stays low for the requested integration length, then goes high and stays high for the rest of the period. The rising edge ends integration and also launches the readout of that line. The period is 300 master clocks in the fast 10-bit mode and 600 in the slow 11-bit mode. At 37.5 MHz this is 8 us and 16 us. The requested length is clamped so that at least 60 clocks of high time remain. A one-cycle line strobe marks every rising edge of the pulse. Mode and integration length are sampled only at the falling edge that opens a period.

Top module: `lsens_timing_ctrl`

## Requirements
- R1: While rst_n is low, pll_rst_n=1, pix_rst_n=1, start_o=1, ready=0 and line_stb=0.
- R2: Counting clock edges after rst_n is released, pll_rst_n first reads 0 after edge PWRUP_CYC. The default is 3750, which is 100 us at 37.5 MHz.
- R3: pll_rst_n is low for exactly RST_CYC cycles (default 5). pix_rst_n then goes low on the same edge that releases pll_rst_n and is low for exactly RST_CYC cycles. The two lines are never low together.
- R4: ready goes to 1 on the edge that releases pix_rst_n and stays at 1 until reset. While ready is 0, start_o stays at 1.
- R5: While enable stays high, successive falling edges of start_o are 300 cycles apart when mode_slow=0 and 600 cycles apart when mode_slow=1.
- R6: The low time of start_o is int_len cycles, clamped to the range 1 to P-60, where P is the period from R5. So int_len=0 gives 1 cycle, and the largest value is 240 in fast mode or 540 in slow mode.
- R7: line_stb is high for exactly the one cycle in which start_o has just risen, and at no other time.
- R8: mode_slow and int_len are sampled only on the edge that starts a period. A change made at any other time does not affect the period in progress.
- R9: If enable is low when a period ends, start_o stays at 1 and no further period starts. If enable is high at an edge while ready and idle, start_o falls on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| enable | input | 1 | Allow start pulse periods |
| mode_slow | input | 1 | 0: fast 10-bit mode, 1: slow 11-bit mode |
| int_len | input | INT_W | Requested integration length in clocks |
| pll_rst_n | output | 1 | Sensor PLL reset, active low |
| pix_rst_n | output | 1 | Sensor all-pixel reset, active low |
| start_o | output | 1 | Master start pulse; low during integration |
| ready | output | 1 | Both resets are done |
| line_stb | output | 1 | One-cycle strobe at each rising edge of start_o |

## Verification
The end of one period and the launch of the next fall on the same clock edge. A change to mode, length or enable placed at exactly that edge must be taken by the new period. A change placed one cycle earlier or later must leave the period in progress alone. The bench provokes this by choosing, at random, to change int_len or mode on the final cycle of a period. It also toggles enable at random. A reference model checks every cycle, using the input values present at each edge, so a design that latches one cycle early or late is caught on start_o or line_stb.

// File: rtl/lsens_timing_ctrl.sv
`timescale 1ns/1ps
module lsens_timing_ctrl #(
  parameter int PWRUP_CYC = 3750,
  parameter int RST_CYC   = 5,
  parameter int PERIOD_HS = 300,
  parameter int HIGH_MIN  = 60,
  parameter int INT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode_slow,
  input  logic [INT_W-1:0] int_len,
  output logic             pll_rst_n,
  output logic             pix_rst_n,
  output logic             start_o,
  output logic             ready,
  output logic             line_stb
);
  localparam int PER_MAX = 2 * PERIOD_HS;
  localparam int PW = $clog2(PER_MAX + 1);
  localparam int CW = $clog2(PWRUP_CYC + 1);
  localparam int XW = (INT_W > PW) ? INT_W : PW;

  typedef enum logic [2:0] {
    ST_WAIT = 3'b011,
    ST_PLL  = 3'b010,
    ST_PIX  = 3'b001,
    ST_RUN  = 3'b111
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          run;
  logic [PW-1:0] pc, cur_p, cur_lo, p_req, lo_req;
  logic [XW-1:0] lim_x, len_x, lo_x;
  logic          start_q, stb_q, last, launch;
  logic [PW-1:0] pc_nx;

  assign pll_rst_n = st[0];
  assign pix_rst_n = st[1];
  assign ready     = st[2];
  assign start_o   = start_q;
  assign line_stb  = stb_q;

  assign p_req  = mode_slow ? PW'(PER_MAX) : PW'(PERIOD_HS);
  assign lim_x  = XW'(p_req - PW'(HIGH_MIN));
  assign len_x  = XW'(int_len);
  assign lo_x   = (len_x == '0) ? XW'(1) : ((len_x > lim_x) ? lim_x : len_x);
  assign lo_req = PW'(lo_x);

  assign last   = run && (pc == cur_p - PW'(1));
  assign launch = (st == ST_RUN) && enable && (!run || last);
  assign pc_nx  = pc + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_WAIT;
      cnt     <= '0;
      run     <= 1'b0;
      pc      <= '0;
      cur_p   <= PW'(PERIOD_HS);
      cur_lo  <= PW'(1);
      start_q <= 1'b1;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      unique case (st)
        ST_WAIT:
          if (cnt == CW'(PWRUP_CYC - 1)) begin st <= ST_PLL; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        ST_PLL:
          if (cnt == CW'(RST_CYC - 1)) begin st <= ST_PIX; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        ST_PIX:
          if (cnt == CW'(RST_CYC - 1)) begin st <= ST_RUN; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        ST_RUN:
          if (launch) begin
            run     <= 1'b1;
            pc      <= '0;
            cur_p   <= p_req;
            cur_lo  <= lo_req;
            start_q <= 1'b0;
          end else if (run) begin
            if (last) begin
              run     <= 1'b0;
              start_q <= 1'b1;
            end else begin
              pc      <= pc_nx;
              start_q <= (pc_nx >= cur_lo);
              stb_q   <= (pc_nx == cur_lo);
            end
          end
        default: st <= ST_WAIT;
      endcase
    end
  end

  p_reset_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst_n || pix_rst_n);
  p_pix_after_pll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_rst_n) |-> $rose(pll_rst_n));
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> start_o);
  p_ready_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_low_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (cur_lo >= PW'(1)) && (cur_lo <= cur_p - PW'(HIGH_MIN)));
  p_stb_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_o) |-> line_stb);
  p_stb_only_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |-> $rose(start_o));
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> ($stable(cur_p) && $stable(cur_lo)));
endmodule

// File: tb/lsens_timing_ctrl_tb_top.sv
`timescale 1ns/1ps
module lsens_timing_ctrl_tb_top;
  localparam int PWRUP = 3750;
  localparam int RSTC  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic mode_slow = 1'b0;
  logic [9:0] int_len = 10'd200;
  logic pll_rst_n, pix_rst_n, start_o, ready, line_stb;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit m_run = 0;
  int m_pc = 0, m_p = 300, m_lo = 1;
  int n = 0;

  always #4 clk = ~clk;

  lsens_timing_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_slow(mode_slow),
    .int_len(int_len), .pll_rst_n(pll_rst_n), .pix_rst_n(pix_rst_n),
    .start_o(start_o), .ready(ready), .line_stb(line_stb));

  function automatic int ref_p(bit slow);
    return slow ? 600 : 300;
  endfunction

  function automatic int ref_lo(int len, bit slow);
    int cap = ref_p(slow) - 60;
    if (len == 0) return 1;
    if (len > cap) return cap;
    return len;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, n);
    end
  endtask

  task automatic step();
    bit e_en = enable;
    bit e_slow = mode_slow;
    int e_len = int'(int_len);
    bit e_rdy = ready;
    bit launch;
    bit exp_start, exp_stb;
    @(negedge clk);
    n++;
    launch = e_rdy && e_en && (!m_run || m_pc == m_p - 1);
    if (launch) begin
      m_run = 1; m_pc = 0; m_p = ref_p(e_slow); m_lo = ref_lo(e_len, e_slow);
    end else if (m_run) begin
      if (m_pc == m_p - 1) m_run = 0;
      else m_pc++;
    end
    exp_start = !m_run || (m_pc >= m_lo);
    exp_stb = m_run && (m_pc == m_lo);
    if (m_run && m_pc == 0) chk(start_o == exp_start, "R5/R9 fall", start_o, exp_start);
    else chk(start_o == exp_start, "R6/R8 start", start_o, exp_start);
    chk(line_stb == exp_stb, "R7 strobe", line_stb, exp_stb);
  endtask

  task automatic run_cycles(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic wait_last();
    int guard = 0;
    while (!(m_run && m_pc == m_p - 2) && guard < 1000) begin step(); guard++; end
    step();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(pll_rst_n == 1 && pix_rst_n == 1, "R1 resets idle", {pll_rst_n, pix_rst_n}, 3);
    chk(start_o == 1 && ready == 0 && line_stb == 0, "R1 start/ready/stb",
        {start_o, ready, line_stb}, 4);
    rst_n = 1'b1;
    for (int i = 0; i < PWRUP + 2 * RSTC + 4; i++) begin
      if (n == PWRUP + 2) enable = 1'b1;
      step();
      chk(pll_rst_n == !(n >= PWRUP && n < PWRUP + RSTC), "R2/R3 pll", pll_rst_n,
          !(n >= PWRUP && n < PWRUP + RSTC));
      chk(pix_rst_n == !(n >= PWRUP + RSTC && n < PWRUP + 2 * RSTC), "R3 pix", pix_rst_n,
          !(n >= PWRUP + RSTC && n < PWRUP + 2 * RSTC));
      chk(ready == (n >= PWRUP + 2 * RSTC), "R4 ready", ready, n >= PWRUP + 2 * RSTC);
    end
    // directed clamp corners (R6), each over two periods
    int_len = 10'd0;    run_cycles(700);
    int_len = 10'd1023; run_cycles(700);
    int_len = 10'd240;  run_cycles(700);
    int_len = 10'd241;  run_cycles(700);
    mode_slow = 1'b1; int_len = 10'd1023; run_cycles(1300);
    int_len = 10'd540;  run_cycles(1300);
    // R8: change mid-period, then exactly on the last cycle
    mode_slow = 1'b0; int_len = 10'd100; run_cycles(450);
    int_len = 10'd30; mode_slow = 1'b1; run_cycles(5);
    wait_last(); int_len = 10'd7; mode_slow = 1'b0; run_cycles(400);
    // R9: drop enable on the last cycle, idle, then restart
    wait_last(); enable = 1'b0; run_cycles(900);
    chk(start_o == 1, "R9 idle high", start_o, 1);
    enable = 1'b1; step();
    chk(start_o == 0, "R9 restart", start_o, 0);
    // constrained random
    for (int i = 0; i < 120000; i++) begin
      if (m_run && m_pc == m_p - 1 && ($urandom % 4) == 0) int_len = 10'($urandom);
      if (($urandom % 150) == 0) int_len = 10'($urandom);
      if (($urandom % 500) == 0) mode_slow = ~mode_slow;
      if (($urandom % 1500) == 0) enable = ~enable;
      step();
    end
    chk(ready == 1, "R4 ready held", ready, 1);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", n, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule